// File: doc/BRIEF.md
# Two-Segment Bus Join Supervisor

This block is the digital controller that sits beside a bidirectional two-wire bus buffer. It watches the clock and data levels on both bus segments (side A and side B), a supply-good indication and an enable pin. From these it decides when the two segments can be joined without corrupting a transfer that is already running on either of them. It also tells the analog section when to run the precharge circuit and the rising-edge accelerators.

The two sides are joined only when both are between transfers in the same cycle. A side counts as between transfers when it shows a stop condition or when it has been idle for a set number of cycles. A separate recovery block reports stuck-bus faults and their clearing. After a fault, the user can force an immediate join by pulling enable low and then high again.

All bus, enable and supply inputs are asynchronous. Each one passes through a two-flop synchronizer. After an input changes, the outputs react within three rising clock edges.

Top module: `seg_join_ctrl`

## Requirements
- R1: While supplyOk is low, connect, ready and accelEn are 0 and prechargeEn is 1, whatever the bus pins and enable do.
- R2: No join is attempted until supplyOk and enable are both high. With enable low, an idle bus or a stop condition leaves the block disconnected with prechargeEn at 1.
- R3: A stop condition on a side is data rising while clock stays high. The sides are joined only when both sides qualify in the same cycle. A stop on one side while the other side's data is held low does not join.
- R4: A side is idle after clock and data have both been high for IDLE_CYCLES consecutive cycles counted while monitoring (default 500, which is 50 µs at 10 MHz). Idle can serve as either side's qualification, or both sides' qualification.
- R5: On joining, connect=1, ready=1, accelEn=1 and prechargeEn=0, no more than three clock edges after the qualifying input change.
- R6: A stuckFault pulse disconnects the sides on the next clock edge and turns off ready and accelEn.
- R7: After a fault, taking enable low and then high forces connect=1 within three edges of enable rising, even while the bus is held low.
- R8: A stuckRecovered pulse after a fault restarts monitoring, so a fresh stop or idle is needed before joining. If power comes up while a bus line is held low, the block stays disconnected.
- R9: When enable goes low or supplyOk goes low at any time, connect and ready drop within three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | High when the supply is above the lockout threshold |
| enable | input | 1 | Enable pin, asynchronous |
| sclA | input | 1 | Sampled clock level, side A |
| sdaA | input | 1 | Sampled data level, side A |
| sclB | input | 1 | Sampled clock level, side B |
| sdaB | input | 1 | Sampled data level, side B |
| stuckFault | input | 1 | One-cycle stuck-bus fault indication, synchronous to clk |
| stuckRecovered | input | 1 | One-cycle stuck-bus cleared indication, synchronous to clk |
| connect | output | 1 | Joins side A to side B |
| ready | output | 1 | High while the sides are joined |
| prechargeEn | output | 1 | Runs the precharge circuit |
| accelEn | output | 1 | Enables the rising-edge accelerators |

## Verification
The assertions assume that stuckFault and stuckRecovered come from a block clocked by clk, so they are single-cycle strobes that need no synchronizer. They also assume that enable and supplyOk hold each level for several cycles, so the three-sample windows in the properties see a settled input. The bench drives every input on the falling clock edge. It holds each enable or supply level for at least four cycles, and it pulses the two fault strobes for exactly one cycle.

// File: rtl/seg_join_pkg.sv
package seg_join_pkg;

  localparam int NUM_SIDES = 2;

  typedef enum logic [2:0] {
    ST_LOCKOUT,
    ST_WAIT_EN,
    ST_MONITOR,
    ST_JOINED,
    ST_FAULT,
    ST_FAULT_EN_LOW
  } joinState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clearIdle;
    logic trackStop;
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic                 supplyGood;
    logic                 enableHigh;
    logic [NUM_SIDES-1:0] sideQual;
  } busStatus_t;

endpackage

// File: rtl/seg_join_datapath.sv
module seg_join_datapath
  import seg_join_pkg::*;
#(
  parameter int IDLE_CYCLES = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 supplyOk,
  input  logic                 enable,
  input  logic [NUM_SIDES-1:0] sclPin,
  input  logic [NUM_SIDES-1:0] sdaPin,
  input  ctrlStrobe_t          strobe,
  output busStatus_t           status
);

  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] IDLE_LIMIT = CNT_W'(IDLE_CYCLES);

  logic [SYNC_STAGES-1:0] supSync;
  logic [SYNC_STAGES-1:0] enSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      supSync <= '0;
      enSync  <= '0;
    end else begin
      supSync <= {supSync[SYNC_STAGES-2:0], supplyOk};
      enSync  <= {enSync[SYNC_STAGES-2:0], enable};
    end
  end

  assign status.supplyGood = supSync[SYNC_STAGES-1];
  assign status.enableHigh = enSync[SYNC_STAGES-1];

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    logic [SYNC_STAGES-1:0] sclSync;
    logic [SYNC_STAGES-1:0] sdaSync;
    logic                   sclPrev;
    logic                   sdaPrev;
    logic [CNT_W-1:0]       highCnt;
    logic                   sclNow;
    logic                   sdaNow;
    logic                   stopSeen;
    logic                   idleSeen;

    // reset to the released (high) level of an open-drain bus
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sclSync <= '1;
        sdaSync <= '1;
        sclPrev <= 1'b1;
        sdaPrev <= 1'b1;
      end else begin
        sclSync <= {sclSync[SYNC_STAGES-2:0], sclPin[s]};
        sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaPin[s]};
        sclPrev <= sclNow;
        sdaPrev <= sdaNow;
      end
    end

    assign sclNow = sclSync[SYNC_STAGES-1];
    assign sdaNow = sdaSync[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        highCnt <= '0;
      end else if (strobe.clearIdle || !(sclNow && sdaNow)) begin
        highCnt <= '0;
      end else if (highCnt != IDLE_LIMIT) begin
        highCnt <= highCnt + 1'b1;
      end
    end

    assign stopSeen = strobe.trackStop && sclPrev && sclNow && !sdaPrev && sdaNow;
    assign idleSeen = (highCnt == IDLE_LIMIT);
    assign status.sideQual[s] = stopSeen || idleSeen;
  end

endmodule

// File: rtl/seg_join_control.sv
module seg_join_control
  import seg_join_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  busStatus_t  status,
  input  logic        stuckFault,
  input  logic        stuckRecovered,
  output ctrlStrobe_t strobe,
  output logic        connect,
  output logic        ready,
  output logic        prechargeEn,
  output logic        accelEn
);

  joinState_t stateQ;
  joinState_t stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_LOCKOUT;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    if (!status.supplyGood) begin
      stateD = ST_LOCKOUT;
    end else begin
      unique case (stateQ)
        ST_LOCKOUT, ST_WAIT_EN: begin
          stateD = status.enableHigh ? ST_MONITOR : ST_WAIT_EN;
        end
        ST_MONITOR: begin
          if (!status.enableHigh)   stateD = ST_WAIT_EN;
          else if (stuckFault)      stateD = ST_FAULT;
          else if (&status.sideQual) stateD = ST_JOINED;
        end
        ST_JOINED: begin
          if (!status.enableHigh) stateD = ST_WAIT_EN;
          else if (stuckFault)    stateD = ST_FAULT;
        end
        ST_FAULT: begin
          if (!status.enableHigh)  stateD = ST_FAULT_EN_LOW;
          else if (stuckRecovered) stateD = ST_MONITOR;
        end
        ST_FAULT_EN_LOW: begin
          if (status.enableHigh) stateD = ST_JOINED;
        end
        default: stateD = ST_LOCKOUT;
      endcase
    end
  end

  assign strobe.clearIdle = (stateQ != ST_MONITOR);
  assign strobe.trackStop = (stateQ == ST_MONITOR);

  assign connect     = (stateQ == ST_JOINED);
  assign ready       = (stateQ == ST_JOINED);
  assign accelEn     = (stateQ == ST_JOINED);
  assign prechargeEn = (stateQ == ST_LOCKOUT) || (stateQ == ST_WAIT_EN) ||
                       (stateQ == ST_MONITOR);

endmodule

// File: rtl/seg_join_ctrl.sv
module seg_join_ctrl
  import seg_join_pkg::*;
#(
  parameter int IDLE_CYCLES = 500
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic enable,
  input  logic sclA,
  input  logic sdaA,
  input  logic sclB,
  input  logic sdaB,
  input  logic stuckFault,
  input  logic stuckRecovered,
  output logic connect,
  output logic ready,
  output logic prechargeEn,
  output logic accelEn
);

  ctrlStrobe_t strobe;
  busStatus_t  status;

  seg_join_datapath #(
    .IDLE_CYCLES(IDLE_CYCLES),
    .SYNC_STAGES(2)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .supplyOk(supplyOk),
    .enable  (enable),
    .sclPin  ({sclB, sclA}),
    .sdaPin  ({sdaB, sdaA}),
    .strobe  (strobe),
    .status  (status)
  );

  seg_join_control u_control (
    .clk           (clk),
    .rstN          (rstN),
    .status        (status),
    .stuckFault    (stuckFault),
    .stuckRecovered(stuckRecovered),
    .strobe        (strobe),
    .connect       (connect),
    .ready         (ready),
    .prechargeEn   (prechargeEn),
    .accelEn       (accelEn)
  );

endmodule

// File: rtl/seg_join_checker.sv
module seg_join_checker (
  input logic clk,
  input logic rstN,
  input logic supplyOk,
  input logic enable,
  input logic stuckFault,
  input logic connect,
  input logic ready,
  input logic prechargeEn,
  input logic accelEn
);

  // R1: supply held low for four samples forces the lockout outputs
  a_r1_lockout_outputs: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyOk && !$past(supplyOk) && !$past(supplyOk, 2) && !$past(supplyOk, 3))
      |-> (!connect && !ready && !accelEn && prechargeEn));

  // R5: joined state carries the full set of joined outputs
  a_r5_joined_outputs: assert property (@(posedge clk) disable iff (!rstN)
    connect |-> (ready && accelEn && !prechargeEn));

  // R6: a fault while joined separates the sides on the next edge
  a_r6_fault_disconnects: assert property (@(posedge clk) disable iff (!rstN)
    (connect && stuckFault) |=> (!connect && !accelEn));

  // R9: enable held low for four samples keeps the sides apart
  a_r9_enable_low_apart: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !$past(enable) && !$past(enable, 2) && !$past(enable, 3))
      |-> (!connect && !ready));

endmodule

bind seg_join_ctrl seg_join_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .supplyOk   (supplyOk),
  .enable     (enable),
  .stuckFault (stuckFault),
  .connect    (connect),
  .ready      (ready),
  .prechargeEn(prechargeEn),
  .accelEn    (accelEn)
);

// File: tb/seg_join_ctrl_bench.sv
module seg_join_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int IDLE = 500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0;
  logic enable = 1'b0;
  logic sclA = 1'b1;
  logic sdaA = 1'b1;
  logic sclB = 1'b1;
  logic sdaB = 1'b1;
  logic stuckFault = 1'b0;
  logic stuckRecovered = 1'b0;
  logic connect;
  logic ready;
  logic prechargeEn;
  logic accelEn;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  seg_join_ctrl #(.IDLE_CYCLES(IDLE)) u_seg_join_ctrl (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .enable(enable),
    .sclA(sclA), .sdaA(sdaA), .sclB(sclB), .sdaB(sdaB),
    .stuckFault(stuckFault), .stuckRecovered(stuckRecovered),
    .connect(connect), .ready(ready), .prechargeEn(prechargeEn), .accelEn(accelEn)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // packed outputs: {connect, ready, prechargeEn, accelEn}
  task automatic expectOut(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {connect, ready, prechargeEn, accelEn};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {connect,ready,precharge,accel} actual=%b expected=%b at %0t",
               req, act, exp, $time);
    end
  endtask

  localparam logic [3:0] OUT_APART  = 4'b0010;
  localparam logic [3:0] OUT_JOINED = 4'b1101;
  localparam logic [3:0] OUT_FAULT  = 4'b0000;

  task automatic goApart();
    enable = 1'b0;
    tick(6);
  endtask

  task automatic testReset();
    expectOut("R1 reset", OUT_APART);
  endtask

  task automatic testLockout();
    supplyOk = 1'b0; enable = 1'b1;
    tick(IDLE + 20);
    expectOut("R1 idle bus under lockout", OUT_APART);
    sdaA = 1'b0; sdaB = 1'b0; tick(5);
    sdaA = 1'b1; sdaB = 1'b1; tick(5);
    expectOut("R1 stop under lockout", OUT_APART);
  endtask

  task automatic testEnableLow();
    enable = 1'b0; supplyOk = 1'b1;
    tick(IDLE + 20);
    expectOut("R2 idle bus with enable low", OUT_APART);
    sdaA = 1'b0; sdaB = 1'b0; tick(5);
    sdaA = 1'b1; sdaB = 1'b1; tick(5);
    expectOut("R2 stop with enable low", OUT_APART);
  endtask

  task automatic testIdleJoin();
    enable = 1'b1;
    tick(IDLE - 20);
    expectOut("R4 idle window not yet complete", OUT_APART);
    tick(30);
    expectOut("R4 R5 joined after idle window", OUT_JOINED);
  endtask

  task automatic testEnableDrop();
    enable = 1'b0;
    tick(4);
    expectOut("R9 enable low disconnects", OUT_APART);
  endtask

  task automatic testStopJoin();
    goApart();
    sdaA = 1'b0; sdaB = 1'b0;
    enable = 1'b1;
    tick(IDLE + 100);
    expectOut("R3 data low blocks join", OUT_APART);
    sdaA = 1'b1; sdaB = 1'b1;
    tick(4);
    expectOut("R3 R5 stop on both sides joins", OUT_JOINED);
  endtask

  task automatic testMixedJoin();
    goApart();
    sdaA = 1'b0; sdaB = 1'b1;
    enable = 1'b1;
    tick(IDLE + 100);
    expectOut("R3 side A busy blocks join", OUT_APART);
    sdaA = 1'b1;
    tick(4);
    expectOut("R3 R4 stop on A with idle B joins", OUT_JOINED);
  endtask

  task automatic testOneSideStop();
    goApart();
    sdaA = 1'b0; sdaB = 1'b0;
    enable = 1'b1;
    tick(IDLE + 100);
    sdaA = 1'b1;
    tick(8);
    expectOut("R3 stop on A alone with B low", OUT_APART);
    sdaB = 1'b1;
    tick(8);
    expectOut("R3 stop on B while A not yet idle", OUT_APART);
    tick(IDLE + 10);
    expectOut("R4 both sides idle joins", OUT_JOINED);
  endtask

  task automatic pulseFault();
    stuckFault = 1'b1; tick(1); stuckFault = 1'b0;
  endtask

  task automatic testFaultToggle();
    sclA = 1'b0; sdaA = 1'b0;
    tick(5);
    expectOut("R5 still joined while bus low", OUT_JOINED);
    pulseFault();
    expectOut("R6 fault disconnects", OUT_FAULT);
    tick(20);
    expectOut("R6 stays apart after fault", OUT_FAULT);
    enable = 1'b0;
    tick(6);
    expectOut("R9 enable low after fault", OUT_FAULT);
    enable = 1'b1;
    tick(4);
    expectOut("R7 toggle forces join with bus low", OUT_JOINED);
    sclA = 1'b1; sdaA = 1'b1;
  endtask

  task automatic testRecover();
    pulseFault();
    expectOut("R6 second fault disconnects", OUT_FAULT);
    stuckRecovered = 1'b1; tick(1); stuckRecovered = 1'b0;
    tick(4);
    expectOut("R8 recovery re-enters monitoring", OUT_APART);
    tick(IDLE - 30);
    expectOut("R8 fresh idle needed after recovery", OUT_APART);
    tick(40);
    expectOut("R8 joins after fresh idle", OUT_JOINED);
  endtask

  task automatic testSupplyDrop();
    supplyOk = 1'b0;
    tick(4);
    expectOut("R9 supply loss disconnects", OUT_APART);
  endtask

  task automatic testPowerIntoStuck();
    enable = 1'b1; sdaA = 1'b0;
    tick(10);
    supplyOk = 1'b1;
    tick(4 * IDLE);
    expectOut("R8 power into stuck bus stays apart", OUT_APART);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    testReset();
    testLockout();
    testEnableLow();
    testIdleJoin();
    testEnableDrop();
    testStopJoin();
    testMixedJoin();
    testOneSideStop();
    testFaultToggle();
    testRecover();
    testSupplyDrop();
    testPowerIntoStuck();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule